// File: doc/BRIEF.md
# Dual-Bank Flow-Through Burst Memory

This block models a synchronous burst memory built from two banks. The banks share one address bus, one clock and one set of control strobes, and each bank has its own registered enable. Every word is 72 bits wide: 64 data bits arranged as eight bytes, plus one parity bit per byte.

On each rising edge the block registers the address, the bank enables, the global write and three strobes: a processor-side address strobe, a controller-side address strobe and an advance strobe. With them it starts, continues, suspends or ends a four-word burst in each bank. The processor strobe only opens reads, and only in an enabled bank. The controller strobe opens a read or a write in an enabled bank and deselects a bank that is not enabled. Writes are early writes: the data is stored at the same edge that accepts the command.

Read data is flow-through. The addressed word reaches the output combinationally after the edge, with no output register. An asynchronous output enable gates it. The output is a single 72-bit read bus with a drive flag, meant to feed a bidirectional pad. Each bank also has an asynchronous sleep input. The array depth is set by a parameter.

Top module: `dual_burst_sram`

## Requirements
- R1: Synchronous reset puts every bank in the deselected state. After reset `rd_drive` is 0 and `rd_data` is all zeros until a read burst is started.
- R2: A processor strobe (`ads_proc_n` low) with a bank's enable low loads `addr` into that bank and starts a read, whatever `gwr_n` is. The word at that address is on `rd_data` right after the same edge.
- R3: A processor strobe is ignored by a bank whose enable is high. With the controller strobe high, that bank keeps its burst as if no strobe were present.
- R4: With the processor strobe inactive for a bank, a controller strobe, the bank's enable and `gwr_n` low start a write burst at `addr`. All 72 bits of `wr_data` are stored there at that same edge. A bank in a write burst never raises `rd_drive`.
- R5: A controller strobe with the bank's enable low and `gwr_n` high starts a read burst at `addr`.
- R6: A controller strobe while a bank's enable is high deselects that bank. It stops driving, and no address is used.
- R7: With both address strobes inactive and `adv_n` low, a busy bank steps to the next word. Only the two low address bits count, and they wrap inside the aligned four-word block (...11 goes to ...00). A write burst stores `wr_data` at each new word.
- R8: With both address strobes inactive and `adv_n` high, a busy bank keeps its current word. A read shows the same word again, and a write stores `wr_data` at the same word again.
- R9: When `oe_n` is high, `rd_drive` is 0 and `rd_data` is zero at once, without waiting for a clock edge. The read burst still advances underneath.
- R10: While `sleep[b]` is high, bank b drives nothing and ignores every strobe and write. Its stored words are kept. When it wakes it is deselected.
- R11: Bits 63:0 of a word are data, with byte n in bits 8n+7:8n. Bits 71:64 are parity, with bit 64+n belonging to byte n. All 72 bits are returned exactly as they were written.
- R12: The banks run independently. A strobe aimed at one bank does not change the burst or the contents of the other. When both banks read at once, the lower-numbered bank drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address loaded when a burst starts |
| bank_sel_n | input | N_BANKS | Registered active-low enable, one bit per bank |
| gwr_n | input | 1 | Active-low global write, picks write or read for a controller strobe |
| ads_proc_n | input | 1 | Active-low processor address strobe, read-only start |
| ads_ctrl_n | input | 1 | Active-low controller address strobe, start or deselect |
| adv_n | input | 1 | Active-low advance; high suspends the burst |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | N_BANKS | Asynchronous active-high standby, one bit per bank |
| wr_data | input | 72 | Write word: data in 63:0, parity in 71:64 |
| rd_data | output | 72 | Flow-through read word; zero when not driving |
| rd_drive | output | 1 | High when the read bus should be driven onto the pads |

## Verification
The bench builds the block with `ADDR_W` = 6 and the default of two banks. That makes 64 words per bank, so a burst can start at the very last word of the array and its wrap back to the start of that aligned four-word block can be seen. The same vector table then runs write bursts, read bursts, suspends, deselects and sleep in both banks. With two banks, a strobe can be aimed at one bank while the other is in the middle of a write burst, which shows that each bank decodes its own enable.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BYTE_W    = 8;
    localparam int N_BYTES   = 8;
    localparam int DATA_W    = BYTE_W * N_BYTES;
    localparam int WORD_W    = DATA_W + N_BYTES;
    localparam int BURST_LEN = 4;
    localparam int BURST_W   = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_READ  = 2'd1,
        BK_WRITE = 2'd2
    } bank_mode_e;

    // parity bit n sits at 64+n and covers data byte n
    typedef struct packed {
        logic [N_BYTES-1:0] par;
        logic [DATA_W-1:0]  data;
    } mem_word_t;

    // active-high view of the shared strobes as seen by one bank
    typedef struct packed {
        logic sel;
        logic proc;
        logic ctrl;
        logic adv;
        logic gwr;
    } bus_req_t;

    typedef struct packed {
        logic start_rd;
        logic start_wr;
        logic desel;
        logic step;
        logic hold;
    } bank_cmd_t;

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] pos);
        return pos + 1'b1;
    endfunction

    // processor strobe first (gated by enable), then controller strobe,
    // then continue/suspend of a burst already in progress
    function automatic bank_cmd_t decode_req(input bus_req_t r, input bank_mode_e mode);
        bank_cmd_t c;
        c = '0;
        if (r.proc && r.sel) begin
            c.start_rd = 1'b1;
        end else if (r.ctrl && r.sel) begin
            if (r.gwr) c.start_wr = 1'b1;
            else       c.start_rd = 1'b1;
        end else if (r.ctrl) begin
            c.desel = 1'b1;
        end else if (mode != BK_IDLE) begin
            if (r.adv) c.step = 1'b1;
            else       c.hold = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sbs_bank_ctrl.sv
module sbs_bank_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  bus_req_t          req,
    input  logic [ADDR_W-1:0] addr,
    output bank_mode_e        mode_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);

    bank_cmd_t         cmd;
    bank_mode_e        mode_d;
    logic [ADDR_W-1:0] ptr_d;

    assign cmd = decode_req(req, mode_q);

    always_comb begin
        mode_d = mode_q;
        ptr_d  = ptr_q;
        if (cmd.start_rd) begin
            mode_d = BK_READ;
            ptr_d  = addr;
        end else if (cmd.start_wr) begin
            mode_d = BK_WRITE;
            ptr_d  = addr;
        end else if (cmd.desel) begin
            mode_d = BK_IDLE;
        end else if (cmd.step) begin
            ptr_d = {ptr_q[ADDR_W-1:BURST_W], burst_step(ptr_q[BURST_W-1:0])};
        end
        if (sleep) begin
            mode_d = BK_IDLE;
            ptr_d  = ptr_q;
        end
    end

    // early write: the word lands at the address this edge selects
    assign wr_en   = !sleep && (mode_d == BK_WRITE);
    assign wr_addr = ptr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= BK_IDLE;
            ptr_q  <= '0;
        end else begin
            mode_q <= mode_d;
            ptr_q  <= ptr_d;
        end
    end

endmodule

// File: rtl/sbs_bank_array.sv
module sbs_bank_array
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  mem_word_t         wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output mem_word_t         rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    mem_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    // flow-through: no output register
    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sbs_out_sel.sv
module sbs_out_sel
    import sbs_pkg::*;
#(
    parameter int N_BANKS = 2
) (
    input  logic               oe_n,
    input  logic [N_BANKS-1:0] rd_act,
    input  mem_word_t          words [N_BANKS],
    output logic               drive,
    output mem_word_t          word
);

    mem_word_t pick;

    always_comb begin
        pick = '0;
        for (int b = N_BANKS - 1; b >= 0; b--) begin
            if (rd_act[b]) pick = words[b];
        end
    end

    assign drive = !oe_n && (|rd_act);
    assign word  = drive ? pick : '0;

endmodule

// File: rtl/dual_burst_sram.sv
module dual_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_BANKS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_BANKS-1:0] bank_sel_n,
    input  logic               gwr_n,
    input  logic               ads_proc_n,
    input  logic               ads_ctrl_n,
    input  logic               adv_n,
    input  logic               oe_n,
    input  logic [N_BANKS-1:0] sleep,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_drive
);

    mem_word_t          wr_word;
    mem_word_t          bank_word [N_BANKS];
    logic [N_BANKS-1:0] rd_act;
    mem_word_t          out_word;

    assign wr_word = mem_word_t'(wr_data);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        bus_req_t          req;
        bank_mode_e        mode;
        logic [ADDR_W-1:0] ptr;
        logic              we;
        logic [ADDR_W-1:0] waddr;

        assign req = '{sel:  !bank_sel_n[b],
                       proc: !ads_proc_n,
                       ctrl: !ads_ctrl_n,
                       adv:  !adv_n,
                       gwr:  !gwr_n};

        sbs_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .sleep   (sleep[b]),
            .req     (req),
            .addr    (addr),
            .mode_q  (mode),
            .ptr_q   (ptr),
            .wr_en   (we),
            .wr_addr (waddr)
        );

        sbs_bank_array #(.ADDR_W(ADDR_W)) u_array (
            .clk     (clk),
            .wr_en   (we),
            .wr_addr (waddr),
            .wr_word (wr_word),
            .rd_addr (ptr),
            .rd_word (bank_word[b])
        );

        // sleep gates the drive asynchronously
        assign rd_act[b] = (mode == BK_READ) && !sleep[b];
    end

    sbs_out_sel #(.N_BANKS(N_BANKS)) u_out (
        .oe_n   (oe_n),
        .rd_act (rd_act),
        .words  (bank_word),
        .drive  (rd_drive),
        .word   (out_word)
    );

    assign rd_data = out_word;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
    import sbs_pkg::*;
#(
    parameter int N_BANKS = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [N_BANKS-1:0] bank_sel_n,
    input logic               ads_proc_n,
    input logic               ads_ctrl_n,
    input logic               adv_n,
    input logic               oe_n,
    input logic [N_BANKS-1:0] sleep,
    input logic [WORD_W-1:0]  rd_data,
    input logic               rd_drive
);

    // R1: nothing drives in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !rd_drive);

    // R9: output enable off forces the bus off
    a_r9_oe_blocks: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rd_drive);

    // R9: an undriven bus reads as zero
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> (rd_data == '0));

    // R10: all banks asleep means nobody drives
    a_r10_sleep_all: assert property (@(posedge clk) disable iff (rst)
        (&sleep) |-> !rd_drive);

    // R6: controller strobe with every enable off deselects all banks
    a_r6_desel_all: assert property (@(posedge clk) disable iff (rst)
        (!ads_ctrl_n && (&bank_sel_n)) |=> !rd_drive);

    // R8: a suspended read shows the same word on the next cycle
    a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_drive && ads_proc_n && ads_ctrl_n && adv_n && !(|sleep))
        |=> (!rd_drive || (|sleep) || $stable(rd_data)));

endmodule

bind dual_burst_sram sbs_checker #(.N_BANKS(N_BANKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bank_sel_n (bank_sel_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive)
);

// File: tb/dual_burst_sram_tb.sv
module dual_burst_sram_tb;
    import sbs_pkg::*;

    localparam int ADDR_W  = 6;
    localparam int N_BANKS = 2;
    localparam int VW      = 30;
    localparam int NV      = 29;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst        = 1'b1;
    logic [ADDR_W-1:0]  addr       = '0;
    logic [N_BANKS-1:0] bank_sel_n = '1;
    logic               gwr_n      = 1'b1;
    logic               ads_proc_n = 1'b1;
    logic               ads_ctrl_n = 1'b1;
    logic               adv_n      = 1'b1;
    logic               oe_n       = 1'b0;
    logic [N_BANKS-1:0] sleep      = '0;
    logic [WORD_W-1:0]  wr_data    = '0;
    logic [WORD_W-1:0]  rd_data;
    logic               rd_drive;

    dual_burst_sram #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .bank_sel_n(bank_sel_n),
        .gwr_n(gwr_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
        .adv_n(adv_n), .oe_n(oe_n), .sleep(sleep), .wr_data(wr_data),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [WORD_W-1:0] pat(input int i);
        logic [7:0] k;
        k = 8'(i);
        if (i == 0) return '0;
        return {k ^ 8'hA5, 64'hF0E1_D2C3_B4A5_9687 + {8{k}}};
    endfunction

    task automatic chk_word(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // fields: sel_n, proc_n, ctrl_n, adv_n, gwr_n, oe_n, sleep, addr, wpat, exp_drive, exp_pat, req
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b10,1'b1,1'b0,1'b1,1'b0,1'b1,2'b00,8'h10,4'd1, 1'b0,4'd0, 4'd4},  // R4 write start
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd2, 1'b0,4'd0, 4'd4},  // R4 no drive in write
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd3, 1'b0,4'd0, 4'd7},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd4, 1'b0,4'd0, 4'd7},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd5, 1'b0,4'd0, 4'd7},  // R7 wrap on write
        {2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,8'h00,4'd6, 1'b0,4'd0, 4'd8},  // R8 write hold
        {2'b10,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,8'h10,4'd0, 1'b1,4'd6, 4'd2},  // R2 read despite gwr
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd2, 4'd7},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd3, 4'd7},
        {2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd3, 4'd8},  // R8 read hold
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd4, 4'd7},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd6, 4'd7},  // R7 wrap on read
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,8'h00,4'd0, 1'b0,4'd0, 4'd9},  // R9 oe off
        {2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd2, 4'd8},
        {2'b11,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h20,4'd0, 1'b1,4'd2, 4'd3},  // R3 gated strobe
        {2'b10,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,8'h12,4'd0, 1'b1,4'd3, 4'd5},  // R5 ctrl read
        {2'b11,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b0,4'd0, 4'd6},  // R6 deselect
        {2'b01,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,8'h10,4'd7, 1'b0,4'd0, 4'd4},
        {2'b10,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h10,4'd7, 1'b1,4'd6, 4'd12}, // R12 banks separate
        {2'b11,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b0,4'd0, 4'd6},
        {2'b01,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h10,4'd0, 1'b1,4'd7, 4'd12},
        {2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,2'b10,8'h00,4'd0, 1'b0,4'd0, 4'd10}, // R10 sleep
        {2'b01,1'b1,1'b0,1'b1,1'b0,1'b0,2'b10,8'h10,4'd8, 1'b0,4'd0, 4'd10},
        {2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b0,4'd0, 4'd10}, // wakes deselected
        {2'b01,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h10,4'd0, 1'b1,4'd7, 4'd10}, // contents kept
        {2'b10,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,8'h3F,4'd9, 1'b0,4'd0, 4'd4},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd10,1'b0,4'd0, 4'd7},
        {2'b10,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h3F,4'd0, 1'b1,4'd9, 4'd2},
        {2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,8'h00,4'd0, 1'b1,4'd10,4'd7}  // R7 top of array
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [WORD_W-1:0] w;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk_bit("R1 drive after reset", rd_drive, 1'b0);
        chk_word("R1 data after reset", rd_data, '0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] v_sel;
            logic       v_p, v_c, v_a, v_g, v_o, v_ed;
            logic [1:0] v_sl;
            logic [7:0] v_ad;
            logic [3:0] v_wp, v_ep, v_rq;
            string      tag;
            {v_sel, v_p, v_c, v_a, v_g, v_o, v_sl, v_ad, v_wp, v_ed, v_ep, v_rq} = VEC[i];
            @(negedge clk);
            bank_sel_n = v_sel;
            ads_proc_n = v_p;
            ads_ctrl_n = v_c;
            adv_n      = v_a;
            gwr_n      = v_g;
            oe_n       = v_o;
            sleep      = v_sl;
            addr       = v_ad[ADDR_W-1:0];
            wr_data    = pat(int'(v_wp));
            @(posedge clk);
            #2;
            tag = $sformatf("R%0d vector %0d", v_rq, i);
            chk_bit(tag, rd_drive, v_ed);
            chk_word(tag, rd_data, pat(int'(v_ep)));
        end

        // R11: field layout of a stored word
        w = {8'b1000_0001, 64'h8877_6655_4433_2211};
        @(negedge clk);
        bank_sel_n = 2'b10; ads_proc_n = 1'b1; ads_ctrl_n = 1'b0; gwr_n = 1'b0;
        adv_n = 1'b1; oe_n = 1'b0; sleep = '0; addr = 6'h05; wr_data = w;
        @(negedge clk);
        ads_ctrl_n = 1'b1; ads_proc_n = 1'b0; gwr_n = 1'b1; wr_data = '0;
        @(posedge clk);
        #2;
        chk_word("R11 whole word", rd_data, w);
        for (int n = 0; n < N_BYTES; n++) begin
            chk_word("R11 byte", {64'h0, rd_data[8*n +: 8]}, {64'h0, 8'(8'h11 * (n + 1))});
            chk_bit("R11 parity bit", rd_data[64 + n], (n == 0) || (n == 7));
        end

        // R9: output enable acts between edges
        @(negedge clk);
        ads_proc_n = 1'b1; bank_sel_n = 2'b11;
        #1 oe_n = 1'b1;
        #1;
        chk_bit("R9 async drive off", rd_drive, 1'b0);
        chk_word("R9 async data off", rd_data, '0);
        oe_n = 1'b0;
        #1;
        chk_bit("R9 async drive on", rd_drive, 1'b1);
        chk_word("R9 async data on", rd_data, w);

        // R1: reset in the middle of a read burst
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk_bit("R1 reset mid burst", rd_drive, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk_bit("R1 idle after reset", rd_drive, 1'b0);
        chk_word("R1 zero after reset", rd_data, '0);

        done = 1'b1;
        summary();
    end

endmodule